// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard

This block tracks instructions from a single in-order decode stream as they move through a pool of functional units. It lets each unit start and finish as soon as its own data dependences allow. Each instruction passes through four steps: it is accepted into a unit, it is allowed to fetch its source operands, it executes, and it is allowed to commit its result. The block holds one status entry per unit and one pending-writer tag per architectural register. It raises one-cycle permission pulses toward the units. The units themselves, and all arithmetic, are outside the block. A unit reports back with a single completion pulse.

Decode presents one instruction at a time with a unit class, an operation code, a destination and two source registers. The block accepts it, names the unit it chose, and from then on paces that unit. Read-after-write dependences are resolved when operands are fetched. Write-after-write conflicts hold the instruction at acceptance. Write-after-read conflicts hold a finished result back until every earlier reader has fetched the old value.

Top module: `sb_scoreboard`

## Requirements
- R1: An instruction is accepted only when a unit of its class is idle. The lowest-numbered idle unit of that class is chosen and reported on `iss_unit`. Class codes are 0 integer/load, 1 multiply, 2 add, 3 divide. With default parameters, units 0..4 have classes 0,1,1,2,3.
- R2: An instruction is not accepted while any busy unit has the same destination register.
- R3: While the instruction at the head is held back, `iss_ready` stays low and no later instruction can be accepted, so acceptance follows program order.
- R4: A unit gets `rd_grant` only when neither of its sources waits on a pending producer. Reads may therefore happen out of program order.
- R5: Several units may receive `rd_grant` in the same cycle.
- R6: A unit's `wr_grant` comes no earlier than the cycle after its `fu_done` pulse.
- R7: A finished unit's `wr_grant` is held while another busy unit still has an unread source equal to its destination.
- R8: When a producer gets `wr_grant`, units waiting on it may read from the next cycle on. An instruction accepted in the same cycle as that write treats the source as ready.
- R9: After `wr_grant`, the unit and its destination register are free for a new acceptance in the next cycle.
- R10: After reset, all units are idle, no grant is raised, and `iss_ready` is high for any class.
- R11: Each accepted instruction receives exactly one `rd_grant` and exactly one `wr_grant`.
- R12: `fu_op` presents, for each unit, the operation code of the instruction it holds, from the cycle after acceptance until its write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Decode offers an instruction |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_class | input | CLS_W | Unit class required |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_unit | output | FU_W | Unit chosen for the offered instruction |
| fu_op | output | NUM_FU*OP_W | Operation code held per unit |
| rd_grant | output | NUM_FU | Per-unit pulse: fetch operands now |
| fu_done | input | NUM_FU | Per-unit pulse: result is ready |
| wr_grant | output | NUM_FU | Per-unit pulse: commit result now |

## Verification
The bench builds the block with its defaults: five units in the classes 0,1,1,2,3 and 32 registers. It models unit latencies of 1, 10, 2 and 40 cycles. Having two multipliers brings the lowest-idle selection into reach, where the second multiply must land on the second unit. The 40-cycle divider holds a stale source unread long enough that the adder's finished result waits on a write-after-read hazard. A reload of that same register then stalls at acceptance on a write-after-write conflict. The exact accept, read and write cycle of every instruction is compared with hand-derived values.

// File: rtl/sb_pkg.sv
// Shared types for the scoreboard.
// Assumes: one stage value per functional unit, encoded in two bits.
package sb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,   // unit free
        ST_WAIT_OPS = 2'd1,   // accepted, waiting for sources
        ST_EXEC     = 2'd2,   // operands read, unit computing
        ST_DONE     = 2'd3    // result ready, waiting for write permission
    } fu_stage_e;
endpackage

// File: rtl/sb_unit_select.sv
// Picks the lowest-numbered idle unit whose class matches the request.
// Assumes: FU_CLASS packs one class code per unit, unit 0 in the low bits.
module sb_unit_select #(
    parameter int NUM_FU = 5,
    parameter int CLS_W  = 2,
    parameter int FU_W   = 3,
    parameter logic [NUM_FU*CLS_W-1:0] FU_CLASS = '0
) (
    input  logic [NUM_FU-1:0] busy,
    input  logic [CLS_W-1:0]  req_class,
    output logic              found,
    output logic [FU_W-1:0]   unit
);
    logic [NUM_FU-1:0] cand;

    // One candidate flag per unit: idle and of the requested class.
    for (genvar g = 0; g < NUM_FU; g++) begin : g_cand
        assign cand[g] = !busy[g] && (FU_CLASS[g*CLS_W +: CLS_W] == req_class);
    end

    // Priority encode so that the lowest index wins.
    always_comb begin
        found = |cand;
        unit  = '0;
        for (int u = NUM_FU - 1; u >= 0; u--) begin
            if (cand[u]) unit = FU_W'(u);
        end
    end
endmodule

// File: rtl/sb_war_check.sv
// For each unit, reports whether committing its destination is free of
// write-after-read conflicts: no other busy unit still holds an unread
// source (ready flag set) that names the same register.
module sb_war_check #(
    parameter int NUM_FU = 5,
    parameter int REG_W  = 5
) (
    input  logic [NUM_FU-1:0]            busy,
    input  logic [NUM_FU-1:0][REG_W-1:0] dst,
    input  logic [NUM_FU-1:0][REG_W-1:0] src_j,
    input  logic [NUM_FU-1:0][REG_W-1:0] src_k,
    input  logic [NUM_FU-1:0]            rdy_j,
    input  logic [NUM_FU-1:0]            rdy_k,
    output logic [NUM_FU-1:0]            war_free
);
    // Compare every unit's destination against every other unit's unread sources.
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_free[u] = 1'b1;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u && busy[f] &&
                    ((rdy_j[f] && src_j[f] == dst[u]) ||
                     (rdy_k[f] && src_k[f] == dst[u])))
                    war_free[u] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
// Scoreboard top: per-unit status table, register pending-writer table,
// in-order acceptance, operand-read and write permission pulses.
// Assumes: fu_done pulses once per instruction, only while the unit executes.
// Writer tags are unit index + 1; zero means no pending writer.
module sb_scoreboard #(
    parameter int NUM_FU   = 5,
    parameter int NUM_REGS = 32,
    parameter int CLS_W    = 2,
    parameter int OP_W     = 4,
    parameter logic [NUM_FU*CLS_W-1:0] FU_CLASS = 10'b11_10_01_01_00,
    localparam int REG_W = $clog2(NUM_REGS),
    localparam int FU_W  = $clog2(NUM_FU),
    localparam int QW    = $clog2(NUM_FU + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid,
    output logic                   iss_ready,
    input  logic [CLS_W-1:0]       iss_class,
    input  logic [OP_W-1:0]        iss_op,
    input  logic [REG_W-1:0]       iss_dst,
    input  logic [REG_W-1:0]       iss_src1,
    input  logic [REG_W-1:0]       iss_src2,
    output logic [FU_W-1:0]        iss_unit,
    output logic [NUM_FU*OP_W-1:0] fu_op,
    output logic [NUM_FU-1:0]      rd_grant,
    input  logic [NUM_FU-1:0]      fu_done,
    output logic [NUM_FU-1:0]      wr_grant
);
    import sb_pkg::*;

    fu_stage_e                   stage_q [NUM_FU];
    logic [NUM_FU-1:0][OP_W-1:0] op_q;
    logic [NUM_FU-1:0][REG_W-1:0] fi_q, fj_q, fk_q;
    logic [NUM_FU-1:0][QW-1:0]   qj_q, qk_q;
    logic [NUM_FU-1:0]           rj_q, rk_q;
    logic [QW-1:0]               regstat_q [NUM_REGS];

    logic [NUM_FU-1:0] busy, war_free;
    logic              sel_found, fire;
    logic [FU_W-1:0]   sel_unit;
    logic [QW-1:0]     q1, q2;
    logic              src1_rdy, src2_rdy;

    // True when the producer tagged q commits in this very cycle.
    function automatic logic tag_writing(input logic [QW-1:0] q, input logic [NUM_FU-1:0] wg);
        tag_writing = 1'b0;
        for (int w = 0; w < NUM_FU; w++)
            if (wg[w] && q == QW'(w + 1)) tag_writing = 1'b1;
    endfunction

    // Busy flags, grants and per-unit op output.
    for (genvar g = 0; g < NUM_FU; g++) begin : g_flags
        assign busy[g]     = (stage_q[g] != ST_IDLE);
        assign rd_grant[g] = (stage_q[g] == ST_WAIT_OPS) && rj_q[g] && rk_q[g];
        assign wr_grant[g] = (stage_q[g] == ST_DONE) && war_free[g];
        assign fu_op[g*OP_W +: OP_W] = op_q[g];
    end

    sb_unit_select #(.NUM_FU(NUM_FU), .CLS_W(CLS_W), .FU_W(FU_W), .FU_CLASS(FU_CLASS)) u_sel (
        .busy(busy), .req_class(iss_class), .found(sel_found), .unit(sel_unit));

    sb_war_check #(.NUM_FU(NUM_FU), .REG_W(REG_W)) u_war (
        .busy(busy), .dst(fi_q), .src_j(fj_q), .src_k(fk_q),
        .rdy_j(rj_q), .rdy_k(rk_q), .war_free(war_free));

    // Acceptance: free unit of the class and no pending writer of the destination.
    always_comb begin
        iss_ready = sel_found && (regstat_q[iss_dst] == '0);
        iss_unit  = sel_unit;
        fire      = iss_valid && iss_ready;
        q1        = regstat_q[iss_src1];
        q2        = regstat_q[iss_src2];
        src1_rdy  = (q1 == '0) || tag_writing(q1, wr_grant);
        src2_rdy  = (q2 == '0) || tag_writing(q2, wr_grant);
    end

    // Per-unit status entries: load on accept, advance through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < NUM_FU; u++) begin
                stage_q[u] <= ST_IDLE;
                op_q[u] <= '0;  fi_q[u] <= '0;  fj_q[u] <= '0;  fk_q[u] <= '0;
                qj_q[u] <= '0;  qk_q[u] <= '0;  rj_q[u] <= 1'b0; rk_q[u] <= 1'b0;
            end
        end else begin
            for (int u = 0; u < NUM_FU; u++) begin
                if (fire && sel_unit == FU_W'(u)) begin
                    stage_q[u] <= ST_WAIT_OPS;
                    op_q[u] <= iss_op;
                    fi_q[u] <= iss_dst;  fj_q[u] <= iss_src1;  fk_q[u] <= iss_src2;
                    rj_q[u] <= src1_rdy; rk_q[u] <= src2_rdy;
                    qj_q[u] <= src1_rdy ? '0 : q1;
                    qk_q[u] <= src2_rdy ? '0 : q2;
                end else begin
                    unique case (stage_q[u])
                        ST_WAIT_OPS: begin
                            if (rd_grant[u]) begin
                                stage_q[u] <= ST_EXEC;
                                rj_q[u] <= 1'b0;  rk_q[u] <= 1'b0;
                                qj_q[u] <= '0;    qk_q[u] <= '0;
                            end else begin
                                for (int w = 0; w < NUM_FU; w++) begin
                                    if (wr_grant[w] && qj_q[u] == QW'(w + 1)) begin
                                        rj_q[u] <= 1'b1;  qj_q[u] <= '0;
                                    end
                                    if (wr_grant[w] && qk_q[u] == QW'(w + 1)) begin
                                        rk_q[u] <= 1'b1;  qk_q[u] <= '0;
                                    end
                                end
                            end
                        end
                        ST_EXEC: if (fu_done[u])  stage_q[u] <= ST_DONE;
                        ST_DONE: if (wr_grant[u]) stage_q[u] <= ST_IDLE;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Register pending-writer table: clear on commit, tag on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) regstat_q[r] <= '0;
        end else begin
            for (int u = 0; u < NUM_FU; u++)
                if (wr_grant[u]) regstat_q[fi_q[u]] <= '0;
            if (fire) regstat_q[iss_dst] <= QW'(sel_unit) + QW'(1);
        end
    end

    // Per-unit protocol assertions.
    for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
        a_r9_free_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[g] |=> stage_q[g] == ST_IDLE);
        a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);
        a_r11_single_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[g] |=> !wr_grant[g]);
        a_r6_done_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
            fu_done[g] |-> stage_q[g] == ST_EXEC);
        a_r4_no_pending_producer: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |-> (qj_q[g] == '0 && qk_q[g] == '0));
        a_r2_no_dup_dest: assert property (@(posedge clk) disable iff (!rst_n)
            fire |-> !(busy[g] && fi_q[g] == iss_dst));
    end
endmodule

// File: tb/test_sb_scoreboard.sv
// Bench: driver pushes expected instruction records into a queue in program
// order; the monitor pops one per acceptance and compares grant cycles.
module test_sb_scoreboard;
    localparam int NFU = 5, CLS_W = 2, OP_W = 4, RW = 5, FW = 3, NI = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_ready;
    logic [CLS_W-1:0] iss_class = '0;
    logic [OP_W-1:0]  iss_op = '0;
    logic [RW-1:0]    iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [FW-1:0]    iss_unit;
    logic [NFU*OP_W-1:0] fu_op;
    logic [NFU-1:0]   rd_grant, wr_grant;
    logic [NFU-1:0]   fu_done = '0;

    sb_scoreboard i_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_class(iss_class), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_unit(iss_unit),
        .fu_op(fu_op), .rd_grant(rd_grant), .fu_done(fu_done), .wr_grant(wr_grant));

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int idx; int cls; int dst; int s1; int s2;
        int unit; int iss; int rd; int wr; bit read_seen;
    } item_t;

    item_t prog [NI];
    item_t pend_q [$];
    item_t owner [NFU];
    bit    owned [NFU];
    int    lat [NFU] = '{1, 10, 10, 2, 40};
    int    cnt [NFU];
    int    n_chk = 0, n_fail = 0, cyc = 0, k = 0, written = 0;
    bit    presenting = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add(input int i, input int c, input int d, input int a, input int b,
                       input int u, input int is, input int r, input int w);
        prog[i] = '{idx:i, cls:c, dst:d, s1:a, s2:b, unit:u, iss:is, rd:r, wr:w, read_seen:1'b0};
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 5000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 80);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // idx cls dst s1 s2 unit issue read write
        add(0, 0,  6, 30, 31, 0,  1,  2,  4);   // load
        add(1, 0,  2, 31, 30, 0,  5,  6,  8);   // load, waits for integer unit (R1)
        add(2, 1,  0,  2,  4, 1,  6,  9, 20);   // multiply, waits on load
        add(3, 2,  8,  6,  2, 3,  7,  9, 12);   // subtract, reads with multiply (R5)
        add(4, 3, 10,  0,  6, 4,  8, 21, 62);   // divide, waits on multiply
        add(5, 2,  6,  8,  2, 3, 13, 14, 22);   // add: reads early (R4), write held (R7)
        add(6, 0,  6, 30, 31, 0, 23, 24, 26);   // reload of same destination (R2)
        add(7, 1, 12,  2,  4, 1, 24, 25, 36);   // multiply on first unit
        add(8, 1, 14, 12,  4, 2, 25, 37, 48);   // second multiplier, waits on wr (R8)
        for (int u = 0; u < NFU; u++) begin cnt[u] = 0; owned[u] = 1'b0; end

        // Reset state (R10)
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_grant == '0, "R10", "rd_grant in reset", int'(rd_grant), 0);
        chk(wr_grant == '0, "R10", "wr_grant in reset", int'(wr_grant), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        iss_class = 2'd3;
        @(negedge clk);
        chk(iss_ready == 1'b1, "R10", "iss_ready after reset", int'(iss_ready), 1);
        chk(rd_grant == '0 && wr_grant == '0, "R10", "grants after reset",
            int'(rd_grant | wr_grant), 0);

        for (int c = 1; c <= 75; c++) begin
            @(posedge clk); cyc = c; #1;
            // Fixed-latency unit models.
            for (int u = 0; u < NFU; u++) begin
                if (cnt[u] > 0) begin cnt[u]--; fu_done[u] = (cnt[u] == 0); end
                else fu_done[u] = 1'b0;
            end
            // Driver: present the next instruction and push its expectation.
            if (!presenting) begin
                if (k < NI) begin
                    iss_valid = 1'b1;
                    iss_class = CLS_W'(prog[k].cls);
                    iss_op    = OP_W'(prog[k].idx);
                    iss_dst   = RW'(prog[k].dst);
                    iss_src1  = RW'(prog[k].s1);
                    iss_src2  = RW'(prog[k].s2);
                    pend_q.push_back(prog[k]);
                    k++;
                    presenting = 1'b1;
                end else iss_valid = 1'b0;
            end
            @(negedge clk);
            // Monitor: acceptance.
            if (iss_valid && iss_ready) begin
                item_t it;
                it = pend_q.pop_front();
                chk(cyc == it.iss, "R1 R2 R3 R9", $sformatf("accept cycle I%0d", it.idx), cyc, it.iss);
                chk(int'(iss_unit) == it.unit, "R1", $sformatf("unit I%0d", it.idx), int'(iss_unit), it.unit);
                owner[iss_unit] = it;
                owned[iss_unit] = 1'b1;
                presenting = 1'b0;
            end
            // Monitor: operand reads.
            for (int u = 0; u < NFU; u++) begin
                if (rd_grant[u]) begin
                    if (!owned[u] || owner[u].read_seen) begin
                        chk(1'b0, "R11", $sformatf("stray read unit %0d", u), cyc, 0);
                    end else begin
                        chk(cyc == owner[u].rd, "R4 R5 R8", $sformatf("read cycle I%0d", owner[u].idx),
                            cyc, owner[u].rd);
                        chk(int'(fu_op[u*OP_W +: OP_W]) == owner[u].idx, "R12",
                            $sformatf("op unit %0d", u), int'(fu_op[u*OP_W +: OP_W]), owner[u].idx);
                        owner[u].read_seen = 1'b1;
                        cnt[u] = lat[u];
                    end
                end
            end
            // Monitor: result writes.
            for (int u = 0; u < NFU; u++) begin
                if (wr_grant[u]) begin
                    if (!owned[u] || !owner[u].read_seen) begin
                        chk(1'b0, "R11", $sformatf("stray write unit %0d", u), cyc, 0);
                    end else begin
                        chk(cyc == owner[u].wr, "R6 R7", $sformatf("write cycle I%0d", owner[u].idx),
                            cyc, owner[u].wr);
                        owned[u] = 1'b0;
                        written++;
                    end
                end
            end
        end

        chk(written == NI, "R11", "instructions written", written, NI);
        chk(pend_q.size() == 0, "R3", "instructions left unaccepted", pend_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule